// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is one buffer channel that carries 9-bit words from a write port to a read port. Each port runs on its own free-running clock. The two clocks may be the same net or may be unrelated. A word moves only when both enable inputs of its port are high. Pointers cross between the domains as Gray codes through two-flop synchronizers. Empty is decided in the read domain and Full in the write domain. Both flags stay asserted for a few cycles after the far side has acted, so neither can report space or data that is not there.

Two more flags, Almost-Empty and Almost-Full, compare the occupancy against two offsets. The offsets are held in four 9-bit parts. With the load input high, each enabled write stores the next part into the offset register in this order: empty-offset low, empty-offset high, full-offset low, full-offset high. Each enabled read with load high returns the next part on the read data lines, in the same order. Reset restores both offsets to 7. An output-enable input releases the read data lines to high impedance. The depth is a power of two set by a parameter.

Top module: `pflag_async_fifo`

## Requirements
- R1: With `ofs_ld_i` low, a write is accepted on a rising `wclk_i` edge when both write enables are high and `full_o` is low. A read is accepted on a rising `rclk_i` edge when both read enables are high and `empty_o` is low. Accepted words leave in the order they entered, and each one is on `rd_data_o` after the read edge that takes it.
- R2: If either enable of a port is low, that port does nothing: no word is stored, and `rd_data_o` keeps its value.
- R3: `empty_o` is high while the read side sees no stored word. After a write into an empty FIFO with the clocks tied, `empty_o` is still high after the second clock edge and low after the third.
- R4: `full_o` rises right after the write edge that stores the DEPTH-th word. A write attempted while `full_o` is high is dropped and overwrites nothing.
- R5: A read attempted while `empty_o` is high is dropped, and `rd_data_o` holds the last word read.
- R6: `almost_empty_o` is high when the occupancy seen by the read side is at most the empty offset, taken as {part1, part0}.
- R7: `almost_full_o` is high when the occupancy seen by the write side is at least DEPTH minus the full offset, taken as {part3, part2}.
- R8: With `ofs_ld_i` high, each enabled write stores `wr_data_i` into offset part 0, 1, 2, 3 in turn and then wraps to part 0. The FIFO contents and `empty_o` are not changed.
- R9: With `ofs_ld_i` high, each enabled read puts offset part 0, 1, 2, 3 in turn on `rd_data_o` and then wraps. The FIFO pointer does not move.
- R10: While `rd_oe_i` is low, all bits of `rd_data_o` are high impedance.
- R11: Reset (`rst_ni` low) empties the FIFO, sets `empty_o` and `almost_empty_o` high and `full_o` and `almost_full_o` low, sets both offsets to 7, and returns both part indexes to part 0.
- R12: With unrelated write and read clocks, every accepted word is delivered once, in order. The write pointer's Gray code changes by at most one bit per write clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write port clock |
| rclk_i | input | 1 | Read port clock |
| rst_ni | input | 1 | Asynchronous active-low reset for the channel |
| wr_en_a_i | input | 1 | Write enable, first qualifier |
| wr_en_b_i | input | 1 | Write enable, second qualifier |
| wr_data_i | input | 9 | Write data, or offset part while loading |
| rd_en_a_i | input | 1 | Read enable, first qualifier |
| rd_en_b_i | input | 1 | Read enable, second qualifier |
| rd_oe_i | input | 1 | Read data output enable; low gives high impedance |
| ofs_ld_i | input | 1 | Redirects both ports to the offset register |
| rd_data_o | output | 9 | Read data, or offset part during a load read |
| empty_o | output | 1 | FIFO empty, read domain |
| full_o | output | 1 | FIFO full, write domain |
| almost_empty_o | output | 1 | Occupancy at or below the empty offset |
| almost_full_o | output | 1 | Occupancy within the full offset of DEPTH |

## Verification
A wrong pointer shows up at the ports as a lost, repeated or reordered word in the scoreboard. It is seen at the first read after the fault, or when the count is checked at the end of a drain. A wrong synchronizer depth moves the edge where `empty_o` falls, which the tied-clock check sees within three cycles of the write. An offset part written to the wrong slot moves the almost-flag boundary by whole words, and it also reads back in the wrong position during the next load read.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int NUM_OFS_PARTS = 4;

  typedef enum logic [1:0] {
    OFS_AE_LO = 2'd0,
    OFS_AE_HI = 2'd1,
    OFS_AF_LO = 2'd2,
    OFS_AF_HI = 2'd3
  } ofs_sel_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
  import dcf_pkg::*;
#(
  parameter int DW          = 9,
  parameter int AW          = 4,
  parameter int OFS_DEFAULT = 7,
  localparam int PTR_W      = AW + 1,
  localparam int OFS_W      = 2 * DW
) (
  input  logic             wclk_i,
  input  logic             rst_ni,
  input  logic             en_a_i,
  input  logic             en_b_i,
  input  logic             ld_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [PTR_W-1:0] rd_gray_sync_i,
  output logic [PTR_W-1:0] wr_gray_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    waddr_o,
  output logic             full_o,
  output logic             almost_full_o,
  output logic [OFS_W-1:0] ae_ofs_o,
  output logic [OFS_W-1:0] af_ofs_o
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [PTR_W-1:0] gray_to_bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] wr_bin_q, wr_gray_q, wr_bin_nxt, rd_bin_sync, occ;
  logic [OFS_W:0]   af_sum;
  logic             push, ld_go;
  ofs_sel_e         ld_idx_q;
  logic [DW-1:0]    part_w [NUM_OFS_PARTS];

  assign rd_bin_sync = gray_to_bin(rd_gray_sync_i);
  assign occ         = wr_bin_q - rd_bin_sync;
  assign full_o      = (occ == PTR_W'(DEPTH));
  assign push        = en_a_i & en_b_i & ~ld_i & ~full_o;
  assign ld_go       = en_a_i & en_b_i & ld_i;
  assign wr_bin_nxt  = wr_bin_q + PTR_W'(1);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_bin_q  <= '0;
      wr_gray_q <= '0;
    end else if (push) begin
      wr_bin_q  <= wr_bin_nxt;
      wr_gray_q <= wr_bin_nxt ^ (wr_bin_nxt >> 1);
    end
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni)    ld_idx_q <= OFS_AE_LO;
    else if (ld_go) ld_idx_q <= ofs_sel_e'(ld_idx_q + 2'd1);
  end

  // even parts are the low halves and reset to the default distance
  for (genvar p = 0; p < NUM_OFS_PARTS; p++) begin : g_part
    logic [DW-1:0] part_q;
    always_ff @(posedge wclk_i or negedge rst_ni) begin
      if (!rst_ni)
        part_q <= (p % 2 == 0) ? DW'(OFS_DEFAULT) : '0;
      else if (ld_go && ld_idx_q == ofs_sel_e'(p))
        part_q <= wdata_i;
    end
    assign part_w[p] = part_q;
  end

  assign ae_ofs_o = {part_w[OFS_AE_HI], part_w[OFS_AE_LO]};
  assign af_ofs_o = {part_w[OFS_AF_HI], part_w[OFS_AF_LO]};

  assign af_sum        = (OFS_W+1)'(occ) + (OFS_W+1)'(af_ofs_o);
  assign almost_full_o = (af_sum >= (OFS_W+1)'(DEPTH));

  assign wr_gray_o = wr_gray_q;
  assign mem_we_o  = push;
  assign waddr_o   = wr_bin_q[AW-1:0];

  assert_no_overflow_R4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    occ <= PTR_W'(DEPTH));

  assert_full_drops_R4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |=> (wr_bin_q == $past(wr_bin_q)));

  assert_ld_no_push_R8: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ld_i |=> $stable(wr_bin_q));

  assert_af_covers_full_R7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o |-> almost_full_o);

  assert_gray_step_R12: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wr_gray_q ^ $past(wr_gray_q)) <= 1);
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
  import dcf_pkg::*;
#(
  parameter int DW     = 9,
  parameter int AW     = 4,
  localparam int PTR_W = AW + 1,
  localparam int OFS_W = 2 * DW
) (
  input  logic             rclk_i,
  input  logic             rst_ni,
  input  logic             en_a_i,
  input  logic             en_b_i,
  input  logic             ld_i,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic [PTR_W-1:0] wr_gray_sync_i,
  input  logic [OFS_W-1:0] ae_ofs_i,
  input  logic [OFS_W-1:0] af_ofs_i,
  output logic [PTR_W-1:0] rd_gray_o,
  output logic [AW-1:0]    raddr_o,
  output logic             empty_o,
  output logic             almost_empty_o,
  output logic [DW-1:0]    q_o
);
  localparam int DEPTH = 1 << AW;

  function automatic logic [PTR_W-1:0] gray_to_bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PTR_W-1:0] rd_bin_q, rd_gray_q, rd_bin_nxt, wr_bin_sync, occ;
  logic             pop, ld_go;
  ofs_sel_e         rd_idx_q;
  logic [DW-1:0]    q_q, part_sel;

  assign wr_bin_sync    = gray_to_bin(wr_gray_sync_i);
  assign occ            = wr_bin_sync - rd_bin_q;
  assign empty_o        = (occ == '0);
  assign almost_empty_o = (OFS_W'(occ) <= ae_ofs_i);
  assign pop            = en_a_i & en_b_i & ~ld_i & ~empty_o;
  assign ld_go          = en_a_i & en_b_i & ld_i;
  assign rd_bin_nxt     = rd_bin_q + PTR_W'(1);

  always_comb begin
    unique case (rd_idx_q)
      OFS_AE_LO: part_sel = ae_ofs_i[DW-1:0];
      OFS_AE_HI: part_sel = ae_ofs_i[OFS_W-1:DW];
      OFS_AF_LO: part_sel = af_ofs_i[DW-1:0];
      default:   part_sel = af_ofs_i[OFS_W-1:DW];
    endcase
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_bin_q  <= '0;
      rd_gray_q <= '0;
    end else if (pop) begin
      rd_bin_q  <= rd_bin_nxt;
      rd_gray_q <= rd_bin_nxt ^ (rd_bin_nxt >> 1);
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_idx_q <= OFS_AE_LO;
      q_q      <= '0;
    end else if (pop) begin
      q_q      <= mem_rdata_i;
    end else if (ld_go) begin
      q_q      <= part_sel;
      rd_idx_q <= ofs_sel_e'(rd_idx_q + 2'd1);
    end
  end

  assign rd_gray_o = rd_gray_q;
  assign raddr_o   = rd_bin_q[AW-1:0];
  assign q_o       = q_q;

  assert_no_underflow_R5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    occ <= PTR_W'(DEPTH));

  assert_empty_holds_q_R5: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (empty_o && !ld_i) |=> $stable(q_q));

  assert_ld_no_pop_R9: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ld_i |=> $stable(rd_bin_q));

  assert_ae_covers_empty_R6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_o |-> almost_empty_o);
endmodule

// File: rtl/pflag_async_fifo.sv
module pflag_async_fifo #(
  parameter int DW          = 9,
  parameter int AW          = 4,
  parameter int OFS_DEFAULT = 7
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_en_a_i,
  input  logic          wr_en_b_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_a_i,
  input  logic          rd_en_b_i,
  input  logic          rd_oe_i,
  input  logic          ofs_ld_i,
  output logic [DW-1:0] rd_data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          almost_empty_o,
  output logic          almost_full_o
);
  localparam int PTR_W = AW + 1;
  localparam int OFS_W = 2 * DW;

  logic [PTR_W-1:0] wr_gray, rd_gray, wr_gray_rs, rd_gray_ws;
  logic             mem_we;
  logic [AW-1:0]    waddr, raddr;
  logic [DW-1:0]    mem_rdata, q;
  logic [OFS_W-1:0] ae_ofs, af_ofs;

  dcf_sync #(.W(PTR_W)) u_sync_rd2wr (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (rd_gray),
    .q_o   (rd_gray_ws)
  );

  dcf_sync #(.W(PTR_W)) u_sync_wr2rd (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (wr_gray),
    .q_o   (wr_gray_rs)
  );

  dcf_wr_ctrl #(.DW(DW), .AW(AW), .OFS_DEFAULT(OFS_DEFAULT)) u_wr (
    .wclk_i        (wclk_i),
    .rst_ni        (rst_ni),
    .en_a_i        (wr_en_a_i),
    .en_b_i        (wr_en_b_i),
    .ld_i          (ofs_ld_i),
    .wdata_i       (wr_data_i),
    .rd_gray_sync_i(rd_gray_ws),
    .wr_gray_o     (wr_gray),
    .mem_we_o      (mem_we),
    .waddr_o       (waddr),
    .full_o        (full_o),
    .almost_full_o (almost_full_o),
    .ae_ofs_o      (ae_ofs),
    .af_ofs_o      (af_ofs)
  );

  dcf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (mem_we),
    .waddr_i(waddr),
    .wdata_i(wr_data_i),
    .raddr_i(raddr),
    .rdata_o(mem_rdata)
  );

  dcf_rd_ctrl #(.DW(DW), .AW(AW)) u_rd (
    .rclk_i        (rclk_i),
    .rst_ni        (rst_ni),
    .en_a_i        (rd_en_a_i),
    .en_b_i        (rd_en_b_i),
    .ld_i          (ofs_ld_i),
    .mem_rdata_i   (mem_rdata),
    .wr_gray_sync_i(wr_gray_rs),
    .ae_ofs_i      (ae_ofs),
    .af_ofs_i      (af_ofs),
    .rd_gray_o     (rd_gray),
    .raddr_o       (raddr),
    .empty_o       (empty_o),
    .almost_empty_o(almost_empty_o),
    .q_o           (q)
  );

  assign rd_data_o = rd_oe_i ? q : 'z;
endmodule

// File: tb/pflag_async_fifo_bench.sv
`timescale 1ns/1ps
module pflag_async_fifo_bench;
  logic       wclk = 1'b0, rclk_free = 1'b0, tie = 1'b1, rclk;
  logic       rst_ni = 1'b0;
  logic       wa = 0, wb = 0, ra = 0, rb = 0, oe = 1, ld = 0;
  logic [8:0] wd = '0;
  wire  [8:0] rd_data;
  logic       empty, full, aempty, afull;

  always #5 wclk = ~wclk;
  always #8.5 rclk_free = ~rclk_free;
  assign rclk = tie ? wclk : rclk_free;

  pflag_async_fifo u_pflag_async_fifo (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_ni),
    .wr_en_a_i(wa), .wr_en_b_i(wb), .wr_data_i(wd),
    .rd_en_a_i(ra), .rd_en_b_i(rb), .rd_oe_i(oe), .ofs_ld_i(ld),
    .rd_data_o(rd_data), .empty_o(empty), .full_o(full),
    .almost_empty_o(aempty), .almost_full_o(afull)
  );

  int n_chk = 0, n_fail = 0, n_pop = 0;
  logic [8:0] exp_q [$];
  logic rd_pend = 0;
  logic pushed;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_word(logic [8:0] d, logic a = 1, logic b = 1);
    @(negedge wclk);
    wa = a; wb = b; wd = d;
    pushed = a & b & ~ld & ~full;
    if (pushed) exp_q.push_back(d);
    @(posedge wclk);
    #1 wa = 0; wb = 0;
  endtask

  task automatic rd_word(logic a = 1, logic b = 1);
    logic fire;
    @(negedge rclk);
    ra = a; rb = b;
    fire = a & b & ~ld & ~empty;
    @(posedge rclk);
    rd_pend = fire;
    #1 ra = 0; rb = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge wclk);
  endtask

  // monitor: compares every expected read against the scoreboard (R1, R12)
  always @(negedge rclk) begin
    if (rd_pend) begin
      rd_pend = 0;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R1 actual=%0h expected=<none>", rd_data);
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        n_pop++;
        if (rd_data !== e) begin
          n_fail++;
          $display("FAIL R1 actual=%0h expected=%0h", rd_data, e);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    int base;
    idle(3);
    rst_ni = 1;
    idle(1);
    chk("R11 empty", empty, 1);
    chk("R11 aempty", aempty, 1);
    chk("R11 full", full, 0);
    chk("R11 afull", afull, 0);

    oe = 0; #1;
    n_chk++;
    if (rd_data !== 9'bz) begin
      n_fail++;
      $display("FAIL R10 actual=%0h expected=zzz", rd_data);
    end
    oe = 1;

    // R3: empty falls after the third edge when the clocks are tied
    wr_word(9'h055);
    @(negedge wclk); @(negedge wclk);
    chk("R3 empty after 2 edges", empty, 1);
    @(negedge wclk);
    chk("R3 empty after 3 edges", empty, 0);

    // R2: one enable low does nothing
    wr_word(9'h1FF, 1, 0);
    wr_word(9'h1FE, 0, 1);
    rd_word(1, 0);
    rd_word(0, 1);
    chk("R2 rd_data unchanged", rd_data, 0);

    cnt = 1;
    for (int i = 1; i <= 15; i++) begin
      wr_word(9'(9'h010 + i));
      cnt++;
      if (cnt == 8)  chk("R7 afull at 8", afull, 0);
      if (cnt == 9)  chk("R7 afull at 9", afull, 1);
      if (cnt == 15) chk("R4 full at 15", full, 0);
      if (cnt == 16) chk("R4 full at 16", full, 1);
    end
    wr_word(9'h0AA);
    chk("R4 full after dropped write", full, 1);
    idle(3);
    chk("R6 aempty at 16", aempty, 0);

    for (int k = 1; k <= 16; k++) begin
      rd_word();
      if (k == 8) chk("R6 aempty at occ 8", aempty, 0);
      if (k == 9) chk("R6 aempty at occ 7", aempty, 1);
    end
    chk("R1 empty after drain", empty, 1);
    rd_word();
    @(negedge rclk);
    chk("R5 read while empty", rd_data, 9'h01F);
    idle(3);
    chk("R4 full cleared", full, 0);

    // R8/R9: load offsets ae=3, af=2
    ld = 1;
    wr_word(9'd3); wr_word(9'd0); wr_word(9'd2); wr_word(9'd0);
    idle(3);
    chk("R8 load leaves empty", empty, 1);
    rd_word(); chk("R9 part0", rd_data, 3);
    rd_word(); chk("R9 part1", rd_data, 0);
    rd_word(); chk("R9 part2", rd_data, 2);
    rd_word(); chk("R9 part3", rd_data, 0);
    rd_word(); chk("R9 wrap to part0", rd_data, 3);
    @(negedge wclk); ld = 0;

    for (int i = 1; i <= 3; i++) wr_word(9'(9'h100 + i));
    idle(3);
    chk("R6 loaded aempty at 3", aempty, 1);
    wr_word(9'h104);
    idle(3);
    chk("R6 loaded aempty at 4", aempty, 0);
    for (int i = 5; i <= 13; i++) wr_word(9'(9'h100 + i));
    chk("R7 loaded afull at 13", afull, 0);
    wr_word(9'h10E);
    chk("R7 loaded afull at 14", afull, 1);
    for (int k = 0; k < 14; k++) rd_word();
    idle(3);
    chk("R1 scoreboard drained", exp_q.size(), 0);

    // R11: reset restores default offsets and indexes
    @(negedge wclk); rst_ni = 0;
    idle(2);
    rst_ni = 1;
    idle(1);
    chk("R11 empty again", empty, 1);
    chk("R11 afull again", afull, 0);
    @(negedge wclk); ld = 1;
    rd_word(); chk("R11 default part0", rd_data, 7);
    rd_word(); chk("R11 default part1", rd_data, 0);
    rd_word(); chk("R11 default part2", rd_data, 7);
    rd_word(); chk("R11 default part3", rd_data, 0);
    @(negedge wclk); ld = 0;

    // R12: unrelated clocks
    @(negedge wclk); rst_ni = 0; tie = 0;
    #50;
    @(negedge wclk); rst_ni = 1;
    base = n_pop;
    fork
      begin
        for (int i = 0; i < 40; i++) begin
          pushed = 0;
          while (!pushed) wr_word(9'(9'h080 + i));
        end
      end
      begin
        int j = 0;
        while (n_pop - base < 40) begin
          rd_word();
          if (j % 3 == 0) @(negedge rclk);
          j++;
        end
      end
    join
    idle(5);
    chk("R12 all words delivered", n_pop - base, 40);
    chk("R12 nothing left over", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule